// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Chain

This block is a serial test chain that sits between the system logic and the pads of a row of bidirectional port pins. Each pin has three scan stages in series. A data stage samples the raw pad input and later supplies the pad output value. A control stage samples the system output-enable. A pull stage samples the system pull-up request. A set of observe-only stages follows the pin stages on the same serial path. Each observe-only stage watches one system signal and never alters it.

The test access controller steers the chain with four qualifiers. With the data-register clock enable active on a rising TCK edge, the chain either captures parallel values or moves one place toward the serial output, depending on the shift qualifier. With the update qualifier active, the pin stages are copied into hold latches on the falling TCK edge. The external-test qualifier selects what reaches the pads. When it is high, the latches drive the pads. When it is low, the system values reach the pads and the latches can be preloaded without disturbing the board. The chain resets asynchronously through an active-low test reset.

Top module: `bscan_pin_chain`

## Requirements
- R1: While trstN is low, every scan stage and every hold latch is 0. Afterwards, with extest high, padOut, padOe and padPullup are all 0, and a full unload of the chain returns only zeros.
- R2: A rising tck edge with clockDr=1 and shiftDr=0 loads each pin's stages at once. The data stage takes padIn, taken straight from the pad without any synchronizer. The control stage takes sysDir, and the pull stage takes the derived pull-up request.
- R3: A rising tck edge with clockDr=1 and shiftDr=1 moves the chain one place toward scanOut, and scanIn enters the first stage. Chain stage s counts from 0 at scanIn. Pin k owns stage 3k (data), stage 3k+1 (control) and stage 3k+2 (pull). Observe-only cell j owns stage 3*NUM_PINS+j. scanOut shows the last stage.
- R4: A falling tck edge with updateDr=1 copies every pin's three stages into its hold latches. The latches keep their value on all other edges and in all other states.
- R5: With extest=1, pin k drives padOut from its data latch, padOe from its control latch and padPullup from its pull latch.
- R6: With extest=0, padOut equals sysPort and padOe equals sysDir. Capture, shift and update (preload) leave the pads unchanged.
- R7: The system pull-up request for pin k is high exactly when pullupDisable=0, sysDir[k]=0 and sysPort[k]=1. With extest=0 it appears on padPullup[k].
- R8: An observe-only cell always passes obsIn straight to obsOut. It loads obsIn on capture, takes part in shifting, and has no hold latch.
- R9: A rising tck edge with clockDr=0 leaves every scan stage unchanged, whatever shiftDr is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| shiftDr | input | 1 | Selects shift (1) or capture (0) when clockDr is active |
| clockDr | input | 1 | Enables the scan stages on a rising tck edge |
| updateDr | input | 1 | Enables the latch update on a falling tck edge |
| extest | input | 1 | Hands the pads to the hold latches |
| scanIn | input | 1 | Serial input to stage 0 |
| scanOut | output | 1 | Serial output from the last stage |
| pullupDisable | input | 1 | Global pull-up disable from the system |
| sysDir | input | NUM_PINS | System output enable per pin |
| sysPort | input | NUM_PINS | System output data per pin |
| padIn | input | NUM_PINS | Raw level seen at each pad |
| padOut | output | NUM_PINS | Output data to each pad |
| padOe | output | NUM_PINS | Output enable to each pad |
| padPullup | output | NUM_PINS | Pull-up enable to each pad |
| obsIn | input | NUM_OBS | System signals watched by the observe-only cells |
| obsOut | output | NUM_OBS | Unchanged copies of obsIn |

## Verification
The bench loads and unloads a four-pin chain with two observe-only cells, using patterns whose bits differ across stages. A design that swaps the data and control stages, or reverses the pin order, therefore returns a permuted stream. Pads are checked before and after the update with the external-test qualifier low. A design that drives the pads from the latches during preload would show the preloaded values too early. A second shift without an update checks that the pads keep the old latch values; a design that updates the latches on every edge would expose the partly shifted stream. The pull-up truth table is covered with the disable both low and high. A shift attempted with the clock enable low must leave the stages untouched, otherwise the unload would come back shifted.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  // Per-pin stage layout inside the serial path
  localparam int PIN_STAGES = 3;
  localparam int STG_DATA   = 0;
  localparam int STG_CTRL   = 1;
  localparam int STG_PULL   = 2;

  typedef struct packed {
    logic captureEn;
    logic shiftEn;
    logic updateEn;
    logic drivePins;
  } scanStrobes_t;
endpackage

// File: rtl/bsc_ctrl.sv
module bsc_ctrl
  import bsc_pkg::*;
(
  input  logic         shiftDr,
  input  logic         clockDr,
  input  logic         updateDr,
  input  logic         extest,
  output scanStrobes_t strb
);
  always_comb begin
    strb.captureEn = clockDr & ~shiftDr;
    strb.shiftEn   = clockDr & shiftDr;
    strb.updateEn  = updateDr;
    strb.drivePins = extest;
  end
endmodule

// File: rtl/bsc_pin_cell.sv
module bsc_pin_cell
  import bsc_pkg::*;
(
  input  logic                  tck,
  input  logic                  trstN,
  input  scanStrobes_t          strb,
  input  logic                  serIn,
  input  logic                  pullupDisable,
  input  logic                  sysDir,
  input  logic                  sysPort,
  input  logic                  padIn,
  output logic                  padOut,
  output logic                  padOe,
  output logic                  padPullup,
  output logic [PIN_STAGES-1:0] stageQ
);
  logic                  sysPue;
  logic [PIN_STAGES-1:0] holdQ;

  assign sysPue = ~pullupDisable & ~sysDir & sysPort;

  // Capture / shift stages, rising edge
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      stageQ <= '0;
    end else if (strb.captureEn) begin
      stageQ[STG_DATA] <= padIn;
      stageQ[STG_CTRL] <= sysDir;
      stageQ[STG_PULL] <= sysPue;
    end else if (strb.shiftEn) begin
      stageQ <= {stageQ[PIN_STAGES-2:0], serIn};
    end
  end

  // Hold latches, falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) holdQ <= '0;
    else if (strb.updateEn) holdQ <= stageQ;
  end

  always_comb begin
    if (strb.drivePins) begin
      padOut    = holdQ[STG_DATA];
      padOe     = holdQ[STG_CTRL];
      padPullup = holdQ[STG_PULL];
    end else begin
      padOut    = sysPort;
      padOe     = sysDir;
      padPullup = sysPue;
    end
  end

  a_r2_capture_raw: assert property (@(posedge tck) disable iff (!trstN)
    strb.captureEn |=> (stageQ[STG_DATA] == $past(padIn)) &&
                       (stageQ[STG_CTRL] == $past(sysDir)));
  a_r3_shift_step: assert property (@(posedge tck) disable iff (!trstN)
    strb.shiftEn |=> stageQ == {$past(stageQ[PIN_STAGES-2:0]), $past(serIn)});
  a_r9_hold_stages: assert property (@(posedge tck) disable iff (!trstN)
    (!strb.captureEn && !strb.shiftEn) |=> $stable(stageQ));
  a_r4_latch_hold: assert property (@(negedge tck) disable iff (!trstN)
    !strb.updateEn |=> $stable(holdQ));
  a_r4_latch_copy: assert property (@(negedge tck) disable iff (!trstN)
    strb.updateEn |=> holdQ == $past(stageQ));
endmodule

// File: rtl/bsc_obs_cell.sv
module bsc_obs_cell
  import bsc_pkg::*;
(
  input  logic         tck,
  input  logic         trstN,
  input  scanStrobes_t strb,
  input  logic         serIn,
  input  logic         obsIn,
  output logic         obsOut,
  output logic         stageQ
);
  assign obsOut = obsIn;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) stageQ <= 1'b0;
    else if (strb.captureEn) stageQ <= obsIn;
    else if (strb.shiftEn) stageQ <= serIn;
  end

  a_r8_obs_capture: assert property (@(posedge tck) disable iff (!trstN)
    strb.captureEn |=> stageQ == $past(obsIn));
endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
  import bsc_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int NUM_OBS  = 2
) (
  input  logic                tck,
  input  logic                trstN,
  input  scanStrobes_t        strb,
  input  logic                scanIn,
  output logic                scanOut,
  input  logic                pullupDisable,
  input  logic [NUM_PINS-1:0] sysDir,
  input  logic [NUM_PINS-1:0] sysPort,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padPullup,
  input  logic [NUM_OBS-1:0]  obsIn,
  output logic [NUM_OBS-1:0]  obsOut
);
  localparam int PIN_LEN   = NUM_PINS * PIN_STAGES;
  localparam int CHAIN_LEN = PIN_LEN + NUM_OBS;

  logic [CHAIN_LEN-1:0] st;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    logic                  cellIn;
    logic [PIN_STAGES-1:0] cellSt;
    if (k == 0) begin : g_first
      assign cellIn = scanIn;
    end else begin : g_next
      assign cellIn = st[k*PIN_STAGES-1];
    end
    bsc_pin_cell u_cell (
      .tck(tck), .trstN(trstN), .strb(strb), .serIn(cellIn),
      .pullupDisable(pullupDisable), .sysDir(sysDir[k]), .sysPort(sysPort[k]),
      .padIn(padIn[k]), .padOut(padOut[k]), .padOe(padOe[k]),
      .padPullup(padPullup[k]), .stageQ(cellSt)
    );
    assign st[k*PIN_STAGES +: PIN_STAGES] = cellSt;
  end

  for (genvar j = 0; j < NUM_OBS; j++) begin : g_obs
    logic cellSt;
    bsc_obs_cell u_cell (
      .tck(tck), .trstN(trstN), .strb(strb), .serIn(st[PIN_LEN+j-1]),
      .obsIn(obsIn[j]), .obsOut(obsOut[j]), .stageQ(cellSt)
    );
    assign st[PIN_LEN+j] = cellSt;
  end

  assign scanOut = st[CHAIN_LEN-1];

  a_r3_tail_shift: assert property (@(posedge tck) disable iff (!trstN)
    strb.shiftEn |=> scanOut == $past(st[CHAIN_LEN-2]));
endmodule

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain
  import bsc_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int NUM_OBS  = 2
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                shiftDr,
  input  logic                clockDr,
  input  logic                updateDr,
  input  logic                extest,
  input  logic                scanIn,
  output logic                scanOut,
  input  logic                pullupDisable,
  input  logic [NUM_PINS-1:0] sysDir,
  input  logic [NUM_PINS-1:0] sysPort,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padPullup,
  input  logic [NUM_OBS-1:0]  obsIn,
  output logic [NUM_OBS-1:0]  obsOut
);
  scanStrobes_t strb;

  bsc_ctrl u_ctrl (
    .shiftDr(shiftDr), .clockDr(clockDr), .updateDr(updateDr),
    .extest(extest), .strb(strb)
  );

  bsc_chain #(.NUM_PINS(NUM_PINS), .NUM_OBS(NUM_OBS)) u_chain (
    .tck(tck), .trstN(trstN), .strb(strb), .scanIn(scanIn), .scanOut(scanOut),
    .pullupDisable(pullupDisable), .sysDir(sysDir), .sysPort(sysPort),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPullup(padPullup),
    .obsIn(obsIn), .obsOut(obsOut)
  );
endmodule

// File: tb/bscan_pin_chain_test.sv
module bscan_pin_chain_test;
  localparam int NP = 4;
  localparam int NO = 2;
  localparam int L  = 3*NP + NO;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic shiftDr = 1'b0, clockDr = 1'b0, updateDr = 1'b0, extest = 1'b0;
  logic scanIn = 1'b0;
  logic scanOut;
  logic pullupDisable = 1'b0;
  logic [NP-1:0] sysDir = '0, sysPort = '0, padIn = '0;
  logic [NP-1:0] padOut, padOe, padPullup;
  logic [NO-1:0] obsIn = '0;
  logic [NO-1:0] obsOut;

  int tests = 0;
  int failed = 0;
  logic expQ[$];
  string tagQ[$];
  logic sampleReq = 1'b0;

  always #10 tck = ~tck;

  bscan_pin_chain #(.NUM_PINS(NP), .NUM_OBS(NO)) uut (
    .tck(tck), .trstN(trstN), .shiftDr(shiftDr), .clockDr(clockDr),
    .updateDr(updateDr), .extest(extest), .scanIn(scanIn), .scanOut(scanOut),
    .pullupDisable(pullupDisable), .sysDir(sysDir), .sysPort(sysPort),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPullup(padPullup),
    .obsIn(obsIn), .obsOut(obsOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare serial output away from the shifting edge
  always @(negedge tck) begin
    if (sampleReq) begin
      logic e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, {31'b0, scanOut}, {31'b0, e});
    end
  end

  task automatic cyc();
    @(posedge tck);
    #5;
  endtask

  function automatic logic [NP-1:0] pueOf(logic [NP-1:0] d, logic [NP-1:0] p, logic pud);
    return pud ? '0 : (~d & p);
  endfunction

  // Expected captured image from R2, R3, R7, R8
  function automatic logic [L-1:0] capImg();
    logic [L-1:0] v;
    logic [NP-1:0] pu;
    pu = pueOf(sysDir, sysPort, pullupDisable);
    for (int k = 0; k < NP; k++) begin
      v[3*k]   = padIn[k];
      v[3*k+1] = sysDir[k];
      v[3*k+2] = pu[k];
    end
    for (int j = 0; j < NO; j++) v[3*NP+j] = obsIn[j];
    return v;
  endfunction

  // Driver: loads tgt so that stage s ends holding tgt[s]; expects old image out
  task automatic shiftVec(logic [L-1:0] tgt, logic [L-1:0] old, string tag);
    clockDr = 1'b1;
    shiftDr = 1'b1;
    for (int i = 0; i < L; i++) begin
      scanIn = tgt[L-1-i];
      expQ.push_back(old[L-1-i]);
      tagQ.push_back($sformatf("%s bit%0d", tag, L-1-i));
      sampleReq = 1'b1;
      cyc();
    end
    sampleReq = 1'b0;
    clockDr = 1'b0;
    shiftDr = 1'b0;
  endtask

  task automatic capture();
    clockDr = 1'b1;
    shiftDr = 1'b0;
    cyc();
    clockDr = 1'b0;
  endtask

  task automatic update();
    updateDr = 1'b1;
    cyc();
    updateDr = 1'b0;
  endtask

  task automatic checkLatched(logic [L-1:0] img, string tag);
    logic [NP-1:0] o, e, u;
    for (int k = 0; k < NP; k++) begin
      o[k] = img[3*k];
      e[k] = img[3*k+1];
      u[k] = img[3*k+2];
    end
    #1;
    check({tag, " padOut"}, {28'b0, padOut}, {28'b0, o});
    check({tag, " padOe"}, {28'b0, padOe}, {28'b0, e});
    check({tag, " padPullup"}, {28'b0, padPullup}, {28'b0, u});
  endtask

  task automatic checkSystem(string tag);
    #1;
    check({tag, " padOut"}, {28'b0, padOut}, {28'b0, sysPort});
    check({tag, " padOe"}, {28'b0, padOe}, {28'b0, sysDir});
    check({tag, " padPullup"}, {28'b0, padPullup},
          {28'b0, pueOf(sysDir, sysPort, pullupDisable)});
  endtask

  initial begin
    #(20*100000);
    failed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [L-1:0] img1, img2, p1, p2, p3;
    p1 = 14'h2D6B;
    p2 = 14'h1A53;
    p3 = 14'h0C9E;
    repeat (3) cyc();
    trstN = 1'b1;
    cyc();

    // R1: reset state
    extest = 1'b1;
    checkLatched('0, "R1 reset latches");
    extest = 1'b0;
    shiftVec('0, '0, "R1 reset unload");

    // R7: pull-up truth table, disable low, through the system path
    sysDir = 4'b1010; sysPort = 4'b0110; padIn = 4'b1001; obsIn = 2'b10;
    checkSystem("R6 R7 system path A");
    // R8: pass-through
    #1 check("R8 obs passthrough", {30'b0, obsOut}, {30'b0, obsIn});

    // R2 R3 R8: capture then unload, while loading p1
    img1 = capImg();
    capture();
    shiftVec(p1, img1, "R2 R3 capture A");

    // R6: preload does not reach the pads
    checkSystem("R6 before update");
    update();
    checkSystem("R6 after preload");

    // R5: extest drives latched values
    extest = 1'b1;
    checkLatched(p1, "R5 drive p1");

    // R9: no clock enable, shift qualifier toggled
    shiftDr = 1'b1; scanIn = 1'b1;
    repeat (3) cyc();
    shiftDr = 1'b0;
    repeat (2) cyc();
    shiftVec(p2, p1, "R9 hold then unload");

    // R4: latches hold without update
    checkLatched(p1, "R4 hold without update");
    update();
    checkLatched(p2, "R4 after update");

    // R7 with the disable set, R2 capture while extest high
    pullupDisable = 1'b1;
    sysDir = 4'b0000; sysPort = 4'b1011; padIn = 4'b0110; obsIn = 2'b01;
    #1 check("R8 obs passthrough 2", {30'b0, obsOut}, {30'b0, obsIn});
    img2 = capImg();
    capture();
    checkLatched(p2, "R4 capture leaves latches");
    shiftVec(p3, img2, "R2 R7 capture disabled");
    extest = 1'b0;
    checkSystem("R7 disable high");

    pullupDisable = 1'b0;
    checkSystem("R7 dir low port high");
    img2 = capImg();
    capture();
    shiftVec(p1, img2, "R2 R7 capture enabled");
    update();
    extest = 1'b1;
    checkLatched(p1, "R5 drive reloaded");

    repeat (2) cyc();
    check("queue drained", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule